// File: doc/BRIEF.md
# PCIe Receive BAR Hit Decoder

This block watches a 256-bit PCIe receive stream. It works out, for each transaction layer packet (TLP) that starts on a beat, which Base Address Register window the request address falls into. The bus carries up to two packet starts per beat, one in each 128-bit half. Each half has its own result slot: a one-hot BAR code, the number of the function that owns the window, and a flag that marks the function as virtual rather than physical. The flag tells the consumer whether to read the BAR code as a physical-function BAR or as a virtual-function BAR.

The stream beat and its decode results pass through one register stage together. A consumer therefore sees the hit code in the same cycle as the first beat of the packet. Software-visible configuration space is not modelled. Each BAR window is given to the block as static inputs:

- a 64-bit base
- a 64-bit size mask
- an enable
- an owner function number
- a virtual-function flag

In addition, one bit per even/odd pair joins the two BARs of that pair into a single 64-bit BAR.

Top module: `rx_bar_decode`

## Requirements
- R1: Each slot's hit code is one-hot or all-zero. Bit n stands for BAR n (bits 0 to 5). Bits 6 and 7 are always zero.
- R2: When more than one enabled window matches an address, only the lowest-numbered one is reported.
- R3: When a pair (0/1, 2/3, 4/5) is joined as a 64-bit BAR, a hit on it appears on the even bit only. The odd bit of that pair is never set.
- R4: A decode is produced only for these packet kinds. Memory read and memory write use fmt 000/001/010/011 with type 00000. Atomic fetch-add, swap and compare-and-swap use fmt 010/011 with types 01100, 01101 and 01110. All other packets, including locked reads (type 00001), configuration requests and completions, give an all-zero result.
- R5: A slot's results are non-zero only in the output cycle that follows an input beat with in_valid high and that slot's start bit set. At all other times they are zero.
- R6: Slot 0 decodes a header in in_data[127:0] and is qualified by in_sop[0]. Slot 1 decodes in_data[255:128] and is qualified by in_sop[1]. The two slots do not affect each other.
- R7: With a hit, the slot's function number and virtual flag equal the winning BAR's configured owner values. Without a hit, both are zero.
- R8: A BAR whose enable is low never matches.
- R9: Within a slot, header dword k sits at bits [32k+31:32k]. fmt is dword 0 bits [31:29] and type is bits [28:24]. fmt bit 0 set selects a 4-dword header with address {dword2, dword3}. Otherwise the address is dword 2 with upper bits zero. A window matches when the address and the base agree on every bit set in the mask. A 32-bit BAR compares the low 32 bits and also needs the upper 32 address bits to be zero. A 64-bit BAR compares all 64 bits.
- R10: out_valid, out_sop and out_data repeat in_valid, in_sop and in_data one cycle later.
- R11: While reset is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 2 | Packet start per 128-bit half |
| in_data | input | 256 | Input beat data |
| cfg_base | input | 384 | Window base per BAR, BAR n at [64n+63:64n] |
| cfg_mask | input | 384 | Window size mask per BAR, same layout |
| cfg_pair64 | input | 3 | Bit p joins BARs 2p and 2p+1 as one 64-bit BAR |
| cfg_en | input | 6 | Enable per BAR |
| cfg_fn | input | 48 | Owner function number per BAR, 8 bits each |
| cfg_vf | input | 6 | Owner is a virtual function, per BAR |
| out_valid | output | 1 | Registered beat valid |
| out_sop | output | 2 | Registered start bits |
| out_data | output | 256 | Registered beat data |
| bar_hit | output | 16 | One-hot hit code, slot s at [8s+7:8s] |
| hit_fn | output | 16 | Function number, slot s at [8s+7:8s] |
| hit_vf | output | 2 | Virtual-function flag per slot |

## Verification
The hardest case to reach from the ports is an address that lies inside several enabled windows at once. Reaching it needs overlapping configuration. It also needs the odd BAR of a pair to become live, which happens only after its pair bit is cleared, so that priority and 64-bit joining are both seen to matter. The stimulus first sets a trap: odd BAR 1 overlaps BAR 2 while pair 0 is joined, so BAR 2 must win. Directed steps then clear the pair bit, and afterwards the odd BAR's enable, and check that the reported bit moves from 0x04 to 0x02 and back. Packets in both halves of one beat, 3-dword headers aimed at 64-bit windows, and 4-dword headers with non-zero upper address bits aimed at 32-bit windows cover the remaining address corners.

// File: rtl/rx_bar_pkg.sv
package rx_bar_pkg;

    localparam int ADDR_W = 64;
    localparam int DW_W   = 32;

    // type field values of interest
    localparam logic [4:0] TYP_MEM    = 5'b00000;
    localparam logic [4:0] TYP_FADD   = 5'b01100;
    localparam logic [4:0] TYP_SWAP   = 5'b01101;
    localparam logic [4:0] TYP_CAS    = 5'b01110;

    typedef struct packed {
        logic              bar_kind;   // packet kind takes part in BAR decode
        logic              is4dw;      // 64-bit address header
        logic [ADDR_W-1:0] addr;
    } hdr_info_t;

endpackage

// File: rtl/rx_hdr_parse.sv
module rx_hdr_parse
    import rx_bar_pkg::*;
#(
    parameter int SLOT_W = 128
) (
    input  logic [SLOT_W-1:0] slot,
    output hdr_info_t         info
);

    logic [DW_W-1:0] dw0, dw2, dw3;
    logic [2:0]      fmt;
    logic [4:0]      typ;
    logic            mem_kind, atom_kind;

    assign dw0 = slot[0*DW_W +: DW_W];
    assign dw2 = slot[2*DW_W +: DW_W];
    assign dw3 = slot[3*DW_W +: DW_W];
    assign fmt = dw0[31:29];
    assign typ = dw0[28:24];

    // memory read / write: fmt 000..011
    assign mem_kind  = (typ == TYP_MEM) && !fmt[2];
    // atomics always carry data: fmt 010 / 011
    assign atom_kind = (fmt[2:1] == 2'b01) &&
                       ((typ == TYP_FADD) || (typ == TYP_SWAP) || (typ == TYP_CAS));

    always_comb begin
        info.bar_kind = mem_kind || atom_kind;
        info.is4dw    = fmt[0];
        info.addr     = fmt[0] ? {dw2, dw3} : {{DW_W{1'b0}}, dw2};
    end

endmodule

// File: rtl/rx_bar_match.sv
module rx_bar_match
    import rx_bar_pkg::*;
#(
    parameter int NUM_BAR = 6,
    parameter int FN_W    = 8,
    parameter int HIT_W   = 8
) (
    input  logic                      qual,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_BAR*ADDR_W-1:0] cfg_base,
    input  logic [NUM_BAR*ADDR_W-1:0] cfg_mask,
    input  logic [NUM_BAR/2-1:0]      cfg_pair64,
    input  logic [NUM_BAR-1:0]        cfg_en,
    input  logic [NUM_BAR*FN_W-1:0]   cfg_fn,
    input  logic [NUM_BAR-1:0]        cfg_vf,
    output logic [HIT_W-1:0]          hit,
    output logic [FN_W-1:0]           fn,
    output logic                      vf
);

    localparam int HALF = ADDR_W / 2;

    logic [NUM_BAR-1:0] win_match;
    logic               hi_zero;

    assign hi_zero = (addr[ADDR_W-1:HALF] == '0);

    for (genvar gi = 0; gi < NUM_BAR; gi++) begin : g_bar
        logic [ADDR_W-1:0] base_i, mask_i;
        logic              lo_eq;
        assign base_i = cfg_base[gi*ADDR_W +: ADDR_W];
        assign mask_i = cfg_mask[gi*ADDR_W +: ADDR_W];
        assign lo_eq  = ((addr[HALF-1:0] ^ base_i[HALF-1:0]) & mask_i[HALF-1:0]) == '0;

        if (gi % 2 == 0) begin : g_even
            logic hi_eq;
            assign hi_eq = ((addr[ADDR_W-1:HALF] ^ base_i[ADDR_W-1:HALF])
                            & mask_i[ADDR_W-1:HALF]) == '0;
            assign win_match[gi] = cfg_en[gi] && lo_eq &&
                                   (cfg_pair64[gi/2] ? hi_eq : hi_zero);
        end else begin : g_odd
            // upper half of a joined pair carries no window of its own
            assign win_match[gi] = cfg_en[gi] && !cfg_pair64[gi/2] && lo_eq && hi_zero;
        end
    end

    // lowest index wins: scan downwards, last writer is the lowest match
    always_comb begin
        hit = '0;
        fn  = '0;
        vf  = 1'b0;
        if (qual) begin
            for (int i = NUM_BAR - 1; i >= 0; i--) begin
                if (win_match[i]) begin
                    hit    = '0;
                    hit[i] = 1'b1;
                    fn     = cfg_fn[i*FN_W +: FN_W];
                    vf     = cfg_vf[i];
                end
            end
        end
    end

endmodule

// File: rtl/rx_bar_decode.sv
module rx_bar_decode
    import rx_bar_pkg::*;
#(
    parameter int NUM_BAR  = 6,
    parameter int FN_W     = 8,
    parameter int HIT_W    = 8,
    parameter int SLOT_W   = 128,
    parameter int NUM_SLOT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NUM_SLOT-1:0]       in_sop,
    input  logic [SLOT_W*NUM_SLOT-1:0] in_data,
    input  logic [NUM_BAR*ADDR_W-1:0] cfg_base,
    input  logic [NUM_BAR*ADDR_W-1:0] cfg_mask,
    input  logic [NUM_BAR/2-1:0]      cfg_pair64,
    input  logic [NUM_BAR-1:0]        cfg_en,
    input  logic [NUM_BAR*FN_W-1:0]   cfg_fn,
    input  logic [NUM_BAR-1:0]        cfg_vf,
    output logic                      out_valid,
    output logic [NUM_SLOT-1:0]       out_sop,
    output logic [SLOT_W*NUM_SLOT-1:0] out_data,
    output logic [NUM_SLOT*HIT_W-1:0] bar_hit,
    output logic [NUM_SLOT*FN_W-1:0]  hit_fn,
    output logic [NUM_SLOT-1:0]       hit_vf
);

    localparam int DATA_W = SLOT_W * NUM_SLOT;

    typedef struct packed {
        logic                      valid;
        logic [NUM_SLOT-1:0]       sop;
        logic [DATA_W-1:0]         data;
        logic [NUM_SLOT*HIT_W-1:0] hit;
        logic [NUM_SLOT*FN_W-1:0]  fn;
        logic [NUM_SLOT-1:0]       vf;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [NUM_SLOT*HIT_W-1:0] slot_hit;
    logic [NUM_SLOT*FN_W-1:0]  slot_fn;
    logic [NUM_SLOT-1:0]       slot_vf;

    for (genvar gs = 0; gs < NUM_SLOT; gs++) begin : g_slot
        hdr_info_t info;
        logic      qual;

        rx_hdr_parse #(.SLOT_W(SLOT_W)) u_parse (
            .slot (in_data[gs*SLOT_W +: SLOT_W]),
            .info (info)
        );

        assign qual = in_valid && in_sop[gs] && info.bar_kind;

        rx_bar_match #(
            .NUM_BAR (NUM_BAR),
            .FN_W    (FN_W),
            .HIT_W   (HIT_W)
        ) u_match (
            .qual       (qual),
            .addr       (info.addr),
            .cfg_base   (cfg_base),
            .cfg_mask   (cfg_mask),
            .cfg_pair64 (cfg_pair64),
            .cfg_en     (cfg_en),
            .cfg_fn     (cfg_fn),
            .cfg_vf     (cfg_vf),
            .hit        (slot_hit[gs*HIT_W +: HIT_W]),
            .fn         (slot_fn[gs*FN_W +: FN_W]),
            .vf         (slot_vf[gs])
        );
    end

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        stage_d.sop   = in_sop;
        stage_d.data  = in_data;
        stage_d.hit   = slot_hit;
        stage_d.fn    = slot_fn;
        stage_d.vf    = slot_vf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign out_sop   = stage_q.sop;
    assign out_data  = stage_q.data;
    assign bar_hit   = stage_q.hit;
    assign hit_fn    = stage_q.fn;
    assign hit_vf    = stage_q.vf;

endmodule

// File: rtl/rx_bar_decode_chk.sv
module rx_bar_decode_chk #(
    parameter int NUM_BAR  = 6,
    parameter int FN_W     = 8,
    parameter int HIT_W    = 8,
    parameter int NUM_SLOT = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [NUM_SLOT-1:0]       in_sop,
    input logic [NUM_BAR/2-1:0]      cfg_pair64,
    input logic [NUM_BAR-1:0]        cfg_en,
    input logic                      out_valid,
    input logic [NUM_SLOT-1:0]       out_sop,
    input logic [NUM_SLOT*HIT_W-1:0] bar_hit,
    input logic [NUM_SLOT*FN_W-1:0]  hit_fn,
    input logic [NUM_SLOT-1:0]       hit_vf
);

    logic               past_ok;
    logic [HIT_W-1:0]   odd_mask;
    logic [HIT_W-1:0]   dis_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        odd_mask = '0;
        dis_mask = '0;
        for (int p = 0; p < NUM_BAR / 2; p++) odd_mask[2*p+1] = cfg_pair64[p];
        for (int b = 0; b < NUM_BAR; b++)     dis_mask[b]     = !cfg_en[b];
    end

    assert_pass_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == $past(in_valid)) && (out_sop == $past(in_sop)));

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && bar_hit == '0 && hit_fn == '0 && hit_vf == '0));

    for (genvar gs = 0; gs < NUM_SLOT; gs++) begin : g_slot_chk
        logic [HIT_W-1:0] h;
        logic [FN_W-1:0]  f;
        assign h = bar_hit[gs*HIT_W +: HIT_W];
        assign f = hit_fn[gs*FN_W +: FN_W];

        assert_hit_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(h) && ((h >> NUM_BAR) == '0));

        assert_odd_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> ((h & $past(odd_mask)) == '0));

        assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> ((h & $past(dis_mask)) == '0));

        assert_unqualified_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !$past(in_valid && in_sop[gs])) |-> (h == '0));

        assert_fn_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (h == '0) |-> (f == '0 && !hit_vf[gs]));
    end

endmodule

bind rx_bar_decode rx_bar_decode_chk #(
    .NUM_BAR  (NUM_BAR),
    .FN_W     (FN_W),
    .HIT_W    (HIT_W),
    .NUM_SLOT (NUM_SLOT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .cfg_pair64 (cfg_pair64),
    .cfg_en     (cfg_en),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .bar_hit    (bar_hit),
    .hit_fn     (hit_fn),
    .hit_vf     (hit_vf)
);

// File: tb/rx_bar_decode_test.sv
module rx_bar_decode_test;

    localparam logic [7:0] MRD3  = 8'b000_00000;
    localparam logic [7:0] MRD4  = 8'b001_00000;
    localparam logic [7:0] MWR3  = 8'b010_00000;
    localparam logic [7:0] MWR4  = 8'b011_00000;
    localparam logic [7:0] FADD4 = 8'b011_01100;
    localparam logic [7:0] CAS3  = 8'b010_01110;
    localparam logic [7:0] CPLD  = 8'b010_01010;
    localparam logic [7:0] MRDLK = 8'b000_00001;
    localparam logic [7:0] CFGRD = 8'b000_00100;

    typedef struct packed {
        logic        vld;
        logic [1:0]  sop;
        logic [7:0]  ft0;
        logic [63:0] a0;
        logic [7:0]  ft1;
        logic [63:0] a1;
        logic [7:0]  eh0;
        logic [7:0]  ef0;
        logic        ev0;
        logic [7:0]  eh1;
        logic [7:0]  ef1;
        logic        ev1;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b01, MRD3,  64'h0000_0000_8000_0123, MRD3,  64'h0000_0000_8000_0000, 8'h04, 8'd3, 1'b0, 8'h00, 8'd0, 1'b0},
        '{1'b1, 2'b10, MRD3,  64'h0000_0000_8000_0000, MWR4,  64'h0000_0010_0000_4000, 8'h00, 8'd0, 1'b0, 8'h01, 8'd0, 1'b0},
        '{1'b1, 2'b11, MWR3,  64'h0000_0000_9000_ABCC, FADD4, 64'h0000_0020_0000_0100, 8'h08, 8'd5, 1'b1, 8'h10, 8'd7, 1'b1},
        '{1'b1, 2'b11, CPLD,  64'h0000_0000_8000_0000, MRDLK, 64'h0000_0000_8000_0000, 8'h00, 8'd0, 1'b0, 8'h00, 8'd0, 1'b0},
        '{1'b1, 2'b11, MRD4,  64'h0000_0001_8000_0000, CAS3,  64'h0000_0000_8000_0FF0, 8'h00, 8'd0, 1'b0, 8'h04, 8'd3, 1'b0},
        '{1'b1, 2'b11, MRD3,  64'h0000_0000_A000_0000, MRD3,  64'h0000_0000_0000_4000, 8'h00, 8'd0, 1'b0, 8'h00, 8'd0, 1'b0},
        '{1'b0, 2'b11, MRD3,  64'h0000_0000_8000_0000, MWR3,  64'h0000_0000_9000_0000, 8'h00, 8'd0, 1'b0, 8'h00, 8'd0, 1'b0},
        '{1'b1, 2'b11, MRD3,  64'h0000_0000_8000_1000, MWR4,  64'h0000_0010_000F_FFFC, 8'h00, 8'd0, 1'b0, 8'h01, 8'd0, 1'b0},
        '{1'b1, 2'b11, MRD4,  64'h0000_0020_0000_FFFC, CFGRD, 64'h0000_0000_8000_0000, 8'h10, 8'd7, 1'b1, 8'h00, 8'd0, 1'b0},
        '{1'b1, 2'b11, MRD4,  64'h0000_0000_9000_0010, MWR3,  64'h0000_0000_8000_0FFC, 8'h08, 8'd5, 1'b1, 8'h04, 8'd3, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_sop = '0;
    logic [255:0] in_data = '0;
    logic [383:0] cfg_base, cfg_mask;
    logic [2:0]   cfg_pair64;
    logic [5:0]   cfg_en, cfg_vf;
    logic [47:0]  cfg_fn;
    logic         out_valid;
    logic [1:0]   out_sop;
    logic [255:0] out_data;
    logic [15:0]  bar_hit, hit_fn;
    logic [1:0]   hit_vf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_bar_decode uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_pair64(cfg_pair64), .cfg_en(cfg_en),
        .cfg_fn(cfg_fn), .cfg_vf(cfg_vf), .out_valid(out_valid), .out_sop(out_sop),
        .out_data(out_data), .bar_hit(bar_hit), .hit_fn(hit_fn), .hit_vf(hit_vf)
    );

    function automatic logic [127:0] mk_slot(logic [7:0] ft, logic [63:0] a);
        logic [31:0] d0, d2, d3;
        d0 = {ft, 24'h000001};
        if (ft[5]) begin d2 = a[63:32]; d3 = a[31:0]; end
        else       begin d2 = a[31:0];  d3 = 32'h0;    end
        return {d3, d2, 32'h0000_00FF, d0};
    endfunction

    task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [1:0] s, logic [7:0] ft0, logic [63:0] a0,
                         logic [7:0] ft1, logic [63:0] a1);
        @(negedge clk);
        in_valid = v;
        in_sop   = s;
        in_data  = {mk_slot(ft1, a1), mk_slot(ft0, a0)};
        @(posedge clk);
        #1;
    endtask

    task automatic set_bar(int i, logic [63:0] b, logic [63:0] m, logic [7:0] f, logic v);
        cfg_base[i*64 +: 64] = b;
        cfg_mask[i*64 +: 64] = m;
        cfg_fn[i*8 +: 8]     = f;
        cfg_vf[i]            = v;
    endtask

    initial begin
        cfg_base = '0; cfg_mask = '0; cfg_fn = '0; cfg_vf = '0;
        set_bar(0, 64'h0000_0010_0000_0000, 64'hFFFF_FFFF_FFF0_0000, 8'd0, 1'b0);
        set_bar(1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_0000, 8'd1, 1'b0);
        set_bar(2, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_F000, 8'd3, 1'b0);
        set_bar(3, 64'h0000_0000_9000_0000, 64'h0000_0000_FFFF_0000, 8'd5, 1'b1);
        set_bar(4, 64'h0000_0020_0000_0000, 64'hFFFF_FFFF_FFFF_0000, 8'd7, 1'b1);
        set_bar(5, 64'h0000_0000_A000_0000, 64'h0000_0000_FFFF_0000, 8'd9, 1'b1);
        cfg_pair64 = 3'b101;
        cfg_en     = 6'b011111;

        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "out_valid in reset", 256'(out_valid), 256'(0));
        chk("R11", "bar_hit in reset", 256'(bar_hit), 256'(0));
        chk("R11", "fn/vf in reset", 256'({hit_fn, hit_vf}), 256'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // vector table: R1 R3 R4 R5 R6 R7 R9 R10
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].vld, VECS[k].sop, VECS[k].ft0, VECS[k].a0, VECS[k].ft1, VECS[k].a1);
            chk("R10", "out_valid", 256'(out_valid), 256'(VECS[k].vld));
            chk("R10", "out_sop", 256'(out_sop), 256'(VECS[k].sop));
            chk("R10", "out_data", out_data,
                {mk_slot(VECS[k].ft1, VECS[k].a1), mk_slot(VECS[k].ft0, VECS[k].a0)});
            chk("R6", "slot0 hit", 256'(bar_hit[7:0]), 256'(VECS[k].eh0));
            chk("R6", "slot1 hit", 256'(bar_hit[15:8]), 256'(VECS[k].eh1));
            chk("R7", "slot0 fn/vf", 256'({hit_fn[7:0], hit_vf[0]}), 256'({VECS[k].ef0, VECS[k].ev0}));
            chk("R7", "slot1 fn/vf", 256'({hit_fn[15:8], hit_vf[1]}), 256'({VECS[k].ef1, VECS[k].ev1}));
        end

        // R2: pair 0 split, BAR1 and BAR2 overlap at 0x8000_0010
        cfg_pair64 = 3'b100;
        set_bar(0, 64'h0000_0000_0000_0000, 64'h0000_0000_FFF0_0000, 8'd0, 1'b0);
        drive(1'b1, 2'b11, MRD3, 64'h8000_0010, MRD3, 64'h0004_0000);
        chk("R2", "overlap picks BAR1", 256'(bar_hit[7:0]), 256'(8'h02));
        chk("R3", "odd BAR reports once split", 256'(hit_fn[7:0]), 256'(8'd1));
        chk("R2", "slot1 32-bit BAR0", 256'(bar_hit[15:8]), 256'(8'h01));

        // R8: disable BAR1, BAR2 takes over
        cfg_en = 6'b011101;
        drive(1'b1, 2'b01, MRD3, 64'h8000_0010, MRD3, 64'h0);
        chk("R8", "disabled BAR1 skipped", 256'(bar_hit[7:0]), 256'(8'h04));
        chk("R8", "fn of BAR2", 256'(hit_fn[7:0]), 256'(8'd3));

        // R4: swap atomic qualifies, fmt 000 atomic type does not
        drive(1'b1, 2'b11, 8'b010_01101, 64'h9000_0004, 8'b000_01101, 64'h9000_0004);
        chk("R4", "swap hits BAR3", 256'(bar_hit[7:0]), 256'(8'h08));
        chk("R4", "atomic type with fmt 000 ignored", 256'(bar_hit[15:8]), 256'(8'h00));

        // R11: asynchronous reset clears a live hit
        drive(1'b1, 2'b01, MRD3, 64'h8000_0010, MRD3, 64'h0);
        chk("R1", "hit before reset", 256'(bar_hit[7:0]), 256'(8'h04));
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R11", "hit cleared by reset", 256'({bar_hit, hit_fn, hit_vf, out_valid}), 256'(0));
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule